// File: doc/BRIEF.md
# Six-State Skip Counter

This block is a three-bit synchronous counter that walks a fixed, irregular loop of six codes: 0, 1, 2, 4, 5, 6, and then 0 again. The codes 3 and 7 are never part of the loop. The counter moves one step on each rising clock edge where the count enable is high. When the enable is low, it keeps its value.

A synchronous reset sets the count to zero. The two skipped codes still have fixed successors, so a counter that powers up in either of them returns to the loop in one enabled step. This makes the block self-starting without relying on reset. Each bit has its own next-state equation: the top bit toggles when the middle bit is set, the middle bit becomes the inverse of itself gated by the low bit, and the low bit sets only when both it and the middle bit are clear.

Top module: `skip_counter`

## Requirements
- R1: A clock edge with `rst` high sets `count` to 3'b000.
- R2: A clock edge with `rst` low and `en` low leaves `count` unchanged.
- R3: With `en` high and `rst` low, each edge moves `count` one step along the loop 000, 001, 010, 100, 101, 110, and back to 000.
- R4: An enabled edge from code 3'b011 gives 3'b100.
- R5: An enabled edge from code 3'b111 gives 3'b000.
- R6: When `count` starts from a loop code, it never takes the value 3'b011 or 3'b111.
- R7: `rst` takes priority over `en`: an edge with both high gives 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| en | input | 1 | Count enable, active high |
| count | output | 3 | Present counter value |

## Verification
The bench focuses on the jump from 2 to 4. A counter built as a plain binary counter would pass through 3 at that step. It also checks the wrap from 6 to 0, which a design without the gap would carry through to 7. Separate instances start in codes 3 and 7, placed there before the first edge, to show that the counter recovers to 4 and to 0. If the recovery were missing, the counter could stay in the unused pair. Steps with the enable low are mixed into the walk and must leave the value unchanged. A reset applied with the enable high must still give zero.

// File: rtl/skip_counter.sv
module skip_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] count
);

  logic [2:0] state_q;
  logic [2:0] state_d;

  assign state_d[2] = state_q[1] ? ~state_q[2] : state_q[2];
  assign state_d[1] = ~state_q[1] & state_q[0];
  assign state_d[0] = ~state_q[1] & ~state_q[0];

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= 3'b000;
    else if (en)
      state_q <= state_d;
  end

  assign count = state_q;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (count == 3'b000));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  assert_jump_past_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (en && count == 3'b010) |=> (count == 3'b100));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (en && count == 3'b110) |=> (count == 3'b000));

  assert_recover_three_R4: assert property (@(posedge clk) disable iff (rst)
    (en && count == 3'b011) |=> (count == 3'b100));

  assert_recover_seven_R5: assert property (@(posedge clk) disable iff (rst)
    (en && count == 3'b111) |=> (count == 3'b000));

  assert_stay_in_loop_R6: assert property (@(posedge clk) disable iff (rst)
    (count != 3'b011 && count != 3'b111) |=> (count != 3'b011 && count != 3'b111));

endmodule

// File: tb/tb_skip_counter.sv
module tb_skip_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       en  = 1'b1;
  logic [2:0] count;
  logic       rst_b = 1'b0;
  logic       en_b  = 1'b1;
  logic [2:0] count_b;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  logic [2:0] model = 3'b000;

  always #4 clk = ~clk;

  skip_counter dut   (.clk(clk), .rst(rst),   .en(en),   .count(count));
  skip_counter dut_b (.clk(clk), .rst(rst_b), .en(en_b), .count(count_b));

  function automatic logic [2:0] loop_next(input logic [2:0] c);
    case (c)
      3'd0: loop_next = 3'd1;
      3'd1: loop_next = 3'd2;
      3'd2: loop_next = 3'd4;
      3'd4: loop_next = 3'd5;
      3'd5: loop_next = 3'd6;
      3'd6: loop_next = 3'd0;
      3'd3: loop_next = 3'd4;
      default: loop_next = 3'd0;
    endcase
  endfunction

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    en  = e;
    if (r) model = 3'b000;
    else if (e) model = loop_next(model);
    exp_q.push_back(model);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      e = exp_q.pop_front();
      check(count, e, (rst ? "R1/R7" : (en ? "R3" : "R2")));
      checks++;
      if (count == 3'b011 || count == 3'b111) begin
        errors++;
        $display("FAIL R6: count=%0d expected a loop code", count);
      end
    end
  end

  initial begin
    force dut.state_q   = 3'b011;
    force dut_b.state_q = 3'b111;
    #1;
    release dut.state_q;
    release dut_b.state_q;
    @(posedge clk); #2;
    check(count,   3'b100, "R4");
    check(count_b, 3'b000, "R5");
    en_b = 1'b0;

    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    for (int i = 0; i < 14; i++) drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, 1'b1);
      drive(1'b0, (i % 2) == 0);
    end
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check(count_b, 3'b000, "R2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule